// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits on the address path of a memory-moving engine. It compares every access address against a set of programmable windows and reports whether a window claims the access. For a claimed access it gives the index of the claiming window and that window's target attribute byte. It also gives a chip-select vector, decoded from the attribute. An access that no window claims raises a decode error in the same cycle.

Windows are set up through a simple write port. There is one shared control word, which holds an enable bit and a 2-bit permission field for each window. Each window also has a base word and a size-mask word. Window sizes and alignment are in 64 KB granules. A separate bypass register forces every access to be claimed with a fixed attribute while it holds a nonzero value.

The decode is combinational. The configuration registers are the only state.

Top module: `dwd_top`

## Requirements
- R1: After reset, every configuration register is zero, so every valid request misses and raises `dec_err`.
- R2: A write with `cfg_we` high loads `cfg_wdata` into register `cfg_addr` at the clock edge, and lookups from the next cycle see it. Register indices are: 0 = control, 1 = bypass, 2+2i = base of window i, 3+2i = size mask of window i.
- R3: Control bit i enables window i. A window whose enable bit is clear never claims an access.
- R4: Control bits [16+2i] and [17+2i] permit reads and writes in window i. A request with `req_write` low needs the read bit, and a request with `req_write` high needs the write bit. The value 0b11 permits both.
- R5: Window i matches when `(req_addr[31:16] ^ base[31:16]) & ~mask[31:16]` is zero. Address bits [15:0] never affect the decode.
- R6: When several windows claim an access, the lowest index wins.
- R7: On a hit, `win_idx` is the winning index and `win_attr` is bits [15:8] of that window's base word.
- R8: `cs_sel` is the inverse of `win_attr[3:0]` when that nibble has exactly one zero bit, for example 0x0E selects bit 0 and 0x07 selects bit 3. Otherwise `cs_sel` is zero; 0x1F gives zero. `cs_sel` is also zero with no hit.
- R9: `dec_err` is high exactly when `req_valid` is high and there is no hit. With no hit, `hit`, `win_idx`, `win_attr` and `cs_sel` are zero.
- R10: While the bypass register is nonzero, every valid request hits with index 0, `win_attr` taken from bypass bits [15:8], and no error. Writing zero to the bypass register restores window decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access address is valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | Access is a write |
| hit | output | 1 | A window claims the access |
| win_idx | output | 3 | Index of the claiming window |
| win_attr | output | 8 | Target attribute of the claiming window |
| cs_sel | output | 4 | One-hot chip select decoded from the attribute |
| dec_err | output | 1 | Valid access claimed by no window |

## Verification
Random window sets are tried with random enables, permissions, masks of 0 to 8 granule bits, and attributes. Addresses are aimed either at a chosen window's span, with random bits in the masked and low positions, or are fully random. These patterns separate the mask compare from the base compare and show that the low address bits play no part. Directed cases cover the following:
- overlapping windows, which exposes priority errors;
- read-only and write-only windows, which separate the two permission bits;
- the four chip-select codes, plus the shared-SRAM window at 0x40000000;
- setting the bypass and then clearing it, checking decoding before and after.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int unsigned GRAN_SHIFT = 16;
  localparam int unsigned ATTR_LSB   = 8;
  localparam int unsigned PERM_LSB   = 16;
  localparam int unsigned CTRL_IDX   = 0;
  localparam int unsigned BYP_IDX    = 1;
  localparam int unsigned WIN_IDX0   = 2;

  // Decode an active-low one-hot chip-select nibble
  function automatic logic [3:0] cs_decode(input logic [7:0] attr);
    logic [3:0] inv;
    inv = ~attr[3:0];
    return ($countones(inv) == 1) ? inv : 4'b0000;
  endfunction
endpackage

// File: rtl/dwd_cfg_regs.sv
module dwd_cfg_regs #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] byp_q,
  output logic [DATA_W-1:0] base_q [NUM_WIN],
  output logic [DATA_W-1:0] mask_q [NUM_WIN]
);
  import dwd_pkg::*;

  logic ctrl_en, byp_en;
  logic [DATA_W-1:0] ctrl_d, byp_d;

  always_comb begin
    ctrl_en = cfg_we && (cfg_addr == REG_AW'(CTRL_IDX));
    byp_en  = cfg_we && (cfg_addr == REG_AW'(BYP_IDX));
    ctrl_d  = cfg_wdata;
    byp_d   = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      byp_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (byp_en)  byp_q  <= byp_d;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic base_en, mask_en;
    always_comb begin
      base_en = cfg_we && (cfg_addr == REG_AW'(WIN_IDX0 + 2*i));
      mask_en = cfg_we && (cfg_addr == REG_AW'(WIN_IDX0 + 2*i + 1));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end else begin
        if (base_en) base_q[i] <= cfg_wdata;
        if (mask_en) mask_q[i] <= cfg_wdata;
      end
    end
  end
endmodule

// File: rtl/dwd_win_match.sv
module dwd_win_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LO     = 16
) (
  input  logic              en,
  input  logic [1:0]        perm,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              match
);
  logic [ADDR_W-LO-1:0] diff;
  logic                 allowed;

  always_comb begin
    diff    = (addr[ADDR_W-1:LO] ^ base[ADDR_W-1:LO]) & ~mask[ADDR_W-1:LO];
    allowed = wr ? perm[1] : perm[0];
    match   = en && allowed && (diff == '0);
  end
endmodule

// File: rtl/dwd_prio_sel.sv
module dwd_prio_sel #(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dwd_top.sv
module dwd_top #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned REG_AW = $clog2(2 + 2*NUM_WIN),
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic [7:0]        win_attr,
  output logic [3:0]        cs_sel,
  output logic              dec_err
);
  import dwd_pkg::*;

  logic [ADDR_W-1:0]    ctrl_q, byp_q;
  logic [ADDR_W-1:0]    base_q [NUM_WIN];
  logic [ADDR_W-1:0]    mask_q [NUM_WIN];
  logic [NUM_WIN-1:0]   win_en;
  logic [2*NUM_WIN-1:0] win_perm;
  logic [NUM_WIN-1:0]   win_match;
  logic                 sel_any;
  logic [IDX_W-1:0]     sel_idx;
  logic                 byp_act;

  dwd_cfg_regs #(.NUM_WIN(NUM_WIN), .DATA_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .byp_q(byp_q),
    .base_q(base_q), .mask_q(mask_q)
  );

  always_comb begin
    win_en   = ctrl_q[NUM_WIN-1:0];
    win_perm = ctrl_q[PERM_LSB +: 2*NUM_WIN];
    byp_act  = (byp_q != '0);
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    dwd_win_match #(.ADDR_W(ADDR_W), .LO(GRAN_SHIFT)) u_match (
      .en(win_en[i]), .perm(win_perm[2*i +: 2]), .base(base_q[i]),
      .mask(mask_q[i]), .addr(req_addr), .wr(req_write),
      .match(win_match[i])
    );
  end

  dwd_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
    .req(win_match), .any(sel_any), .idx(sel_idx)
  );

  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    win_attr = '0;
    if (req_valid) begin
      if (byp_act) begin
        hit      = 1'b1;
        win_attr = byp_q[ATTR_LSB +: 8];
      end else if (sel_any) begin
        hit      = 1'b1;
        win_idx  = sel_idx;
        win_attr = base_q[sel_idx][ATTR_LSB +: 8];
      end
    end
    cs_sel  = hit ? cs_decode(win_attr) : 4'b0000;
    dec_err = req_valid && !hit;
  end
endmodule

// File: rtl/dwd_chk.sv
module dwd_chk #(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned ADDR_W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [REG_AW-1:0]    cfg_addr,
  input logic [ADDR_W-1:0]    cfg_wdata,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 hit,
  input logic [IDX_W-1:0]     win_idx,
  input logic [3:0]           cs_sel,
  input logic                 dec_err,
  input logic                 byp_act,
  input logic [NUM_WIN-1:0]   win_en,
  input logic [2*NUM_WIN-1:0] win_perm
);
  // R3
  en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !byp_act) |-> win_en[win_idx]);
  // R4
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !byp_act) |-> win_perm[2*win_idx + (req_write ? 1 : 0)]);
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!hit && !dec_err && cs_sel == 4'b0));
  // R10
  byp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_act && req_valid) |-> (hit && win_idx == '0 && !dec_err));
  // R10
  byp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_AW'(1) && cfg_wdata == '0) |=> !byp_act);
endmodule

bind dwd_top dwd_chk #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .IDX_W(IDX_W),
                       .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
  .hit(hit), .win_idx(win_idx), .cs_sel(cs_sel), .dec_err(dec_err),
  .byp_act(byp_act), .win_en(win_en), .win_perm(win_perm)
);

// File: tb/dwd_top_tb.sv
`timescale 1ns/1ps
module dwd_top_tb;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        hit, dec_err;
  logic [2:0]  win_idx;
  logic [7:0]  win_attr;
  logic [3:0]  cs_sel;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_ctrl, m_byp;
  logic [31:0] m_base [NW];
  logic [31:0] m_mask [NW];

  always #2.5 clk = ~clk;

  dwd_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .hit(hit), .win_idx(win_idx),
    .win_attr(win_attr), .cs_sel(cs_sel), .dec_err(dec_err)
  );

  function automatic logic [3:0] exp_cs(input logic [7:0] a);
    logic [3:0] v;
    v = ~a[3:0];
    return ($countones(v) == 1) ? v : 4'h0;
  endfunction

  // Expected {hit, idx, attr, cs, err}
  function automatic logic [16:0] model(input logic [31:0] a, input logic w);
    logic h; logic [2:0] ix; logic [7:0] at;
    h = 1'b0; ix = '0; at = '0;
    if (m_byp != 0) begin
      h = 1'b1; at = m_byp[15:8];
    end else begin
      for (int i = NW - 1; i >= 0; i--) begin
        if (m_ctrl[i] && m_ctrl[16 + 2*i + (w ? 1 : 0)] &&
            (((a[31:16] ^ m_base[i][31:16]) & ~m_mask[i][31:16]) == 16'h0)) begin
          h = 1'b1; ix = 3'(i); at = m_base[i][15:8];
        end
      end
    end
    return {h, ix, at, (h ? exp_cs(at) : 4'h0), !h};
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = d;
    @(posedge clk);
    #0.5 cfg_we = 1'b0;
    if (idx == 0) m_ctrl = d;
    else if (idx == 1) m_byp = d;
    else if (idx[0] == 1'b0) m_base[(idx-2)/2] = d;
    else m_mask[(idx-3)/2] = d;
  endtask

  task automatic chk(input logic [31:0] a, input logic w, input string req);
    logic [16:0] e, got;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    #1;
    e = model(a, w);
    got = {hit, win_idx, win_attr, cs_sel, dec_err};
    n_vec++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h wr=%0b actual=%h expected=%h", req, a, w, got, e);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_byp = '0;
    for (int i = 0; i < NW; i++) begin m_base[i] = '0; m_mask[i] = '0; end
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1: reset state misses everywhere
    chk(32'h0000_0000, 1'b0, "R1");
    chk(32'h4000_1234, 1'b1, "R1");
    // R9: idle request drives nothing
    @(negedge clk); #1; n_vec++;
    if ({hit, dec_err, cs_sel} !== 6'b0) begin
      n_bad++; $display("FAIL R9 idle actual=%b expected=0", {hit, dec_err, cs_sel});
    end

    // R2 R7 R8: chip-select windows, 256 MB each
    wr(2, 32'h0000_0E00); wr(3, 32'h0FFF_0000);
    wr(4, 32'h1000_0D00); wr(5, 32'h0FFF_0000);
    wr(6, 32'h2000_0B00); wr(7, 32'h0FFF_0000);
    wr(8, 32'h3000_0700); wr(9, 32'h0FFF_0000);
    wr(10, 32'h4000_1F00); wr(11, 32'h000F_0000);
    wr(0, 32'h0000_03FF | (32'hAAAA << 16));
    chk(32'h0123_4567, 1'b0, "R8");
    chk(32'h1ABC_0000, 1'b1, "R8");
    chk(32'h2000_FFFF, 1'b0, "R7");
    chk(32'h3FFF_FFFF, 1'b1, "R8");
    chk(32'h400F_FFFF, 1'b0, "R7");
    chk(32'h4010_0000, 1'b0, "R9");
    // R5: low address bits ignored
    chk(32'h4000_0001, 1'b1, "R5");
    // R4: read-only window 0, write-only window 1
    wr(0, 32'h0009_001F | 32'hAA80_0000);
    chk(32'h0000_1000, 1'b0, "R4");
    chk(32'h0000_1000, 1'b1, "R4");
    chk(32'h1000_1000, 1'b1, "R4");
    chk(32'h1000_1000, 1'b0, "R4");
    // R3: disable window 2
    wr(0, 32'hFFFF_00FB);
    chk(32'h2000_0000, 1'b0, "R3");
    // R6: overlapping windows, lowest index wins
    wr(14, 32'h2000_5500); wr(15, 32'h0FFF_0000);
    wr(0, 32'hFFFF_00FF);
    chk(32'h2000_0040, 1'b0, "R6");
    wr(0, 32'hFFFF_00FB);
    chk(32'h2000_0040, 1'b1, "R6");
    // R10: bypass on, then cleared
    wr(1, 32'h0000_0D01);
    chk(32'hF000_0000, 1'b1, "R10");
    chk(32'h0000_0000, 1'b0, "R10");
    wr(1, 32'h0);
    chk(32'hF000_0000, 1'b1, "R10");
    chk(32'h1000_0000, 1'b1, "R10");

    // Random windows and addresses
    for (int r = 0; r < 40; r++) begin
      wr(0, $urandom());
      for (int i = 0; i < NW; i++) begin
        wr(2 + 2*i, $urandom());
        wr(3 + 2*i, ((32'h1 << ($urandom() % 9)) - 1) << 16);
      end
      for (int k = 0; k < 12; k++) begin
        int j;
        j = $urandom() % NW;
        if ($urandom() % 4 == 0) a = $urandom();
        else a = {m_base[j][31:16] ^ (16'($urandom()) & m_mask[j][31:16]),
                  16'($urandom())};
        chk(a, 1'($urandom()), "R5");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule